// File: doc/BRIEF.md
# Offset Min-Sum Check-Node Row Unit

This block updates one parity-check row of a layered LDPC decoder. A row arrives block-serially, one or two entries per cycle. Each entry brings a posterior LLR from a memory bank and the check message that the row wrote for that column on the last pass. The unit subtracts the old check message to form the extrinsic (variable-to-check) value and keeps it in a small local buffer. While the entries stream in, it tracks the smallest and second-smallest extrinsic magnitudes, the position of the smallest, and the parity of all extrinsic signs.

Once the last entry of the row is in, a single finalize cycle applies the offset correction to both minima. The unit then replays the row in arrival order, two entries per cycle. For each entry it emits the new check message and the updated posterior. Lane 0 carries odd-bank entries and lane 1 carries even-bank entries. When the row degree is odd, the final lane-1 slot is marked unused, and its logic is switched off both on input and on output. Bank memory, block permutation and layer scheduling are handled outside this block.

Top module: `cnu_row`

## Requirements
- R1: After reset, `out_valid` and `done` are low, and they stay low until a row has been loaded.
- R2: Each extrinsic value is `app - old`, computed exactly and then clamped to the symmetric range [-63, 63] (7-bit two's complement, one fractional bit).
- R3: The new check magnitude for an entry is the smallest extrinsic magnitude among the other entries of the row, minus OFFSET (default 1 LSB), floored at zero. The entry that holds the row minimum therefore receives the corrected second minimum.
- R4: The new check sign is the XOR of the signs of all other extrinsic values in the row. The sign is 1 when the value is negative, and zero counts as positive.
- R5: The new posterior is extrinsic plus new check message, clamped to [-63, 63].
- R6: Entries 2k and 2k+1 of a row are taken on lane 0 and lane 1 of one input cycle. The output pairs follow in the same order, one pair per cycle, with no gaps. The first pair is valid on the second cycle after the cycle that delivered the last entry.
- R7: When `in_lane1_ok` is low on an accepted input cycle, the lane-1 inputs have no effect on any result. On the output pair that matches an odd row's last slot, `out_lane1_ok` is low and `out_chk1` and `out_app1` read 0.
- R8: `done` is high only together with the last output pair of a row, and `out_valid` is low in the cycle that follows it.
- R9: `start` is acted on only while no row is in progress, and `in_valid` is acted on only while a row is loading. At any other time both have no effect.
- R10: The row degree `row_deg`, sampled with `start`, may be any value from 2 to MAXDEG (default 24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a row (used when idle) |
| row_deg | input | 5 | Number of entries in the row |
| in_valid | input | 1 | An input pair is present |
| in_lane1_ok | input | 1 | The lane-1 input entry is part of the row |
| in_app0 | input | 7 | Posterior LLR, lane 0 (odd bank) |
| in_app1 | input | 7 | Posterior LLR, lane 1 (even bank) |
| in_old0 | input | 7 | Previous check message, lane 0 |
| in_old1 | input | 7 | Previous check message, lane 1 |
| out_valid | output | 1 | An output pair is present |
| out_lane1_ok | output | 1 | The lane-1 output entry is part of the row |
| out_app0 | output | 7 | Updated posterior, lane 0 |
| out_app1 | output | 7 | Updated posterior, lane 1 |
| out_chk0 | output | 7 | New check message, lane 0 |
| out_chk1 | output | 7 | New check message, lane 1 |
| done | output | 1 | Marks the last output pair of a row |

## Verification
The assertions assume the following about the inputs:
- `in_lane1_ok` is high on every accepted input cycle except the last one of an odd-degree row.
- `row_deg` stays within 2 to MAXDEG.
- The row delivers exactly its degree in entries.

Under these conditions, the range and zero-lane properties hold for every output pair. The stimulus computes the lane-1 flag from the entries still to come and draws degrees only from the legal range. It drives junk values on a disabled lane, a stray `start`, and `in_valid` while idle, so that the ignore paths are exercised without ever breaking these assumptions.

// File: rtl/cnu_pkg.sv
`timescale 1ns/1ps
package cnu_pkg;
  localparam int LW = 7;
  localparam int MW = LW - 1;

  typedef logic signed [LW-1:0] llr_t;
  typedef logic [MW-1:0]        mag_t;
  typedef struct packed { logic s; mag_t m; } sm_t;
  typedef enum logic [1:0] { S_IDLE, S_LOAD, S_FIN, S_EMIT } cnu_state_t;

  localparam logic signed [LW:0] LIMW = (LW+1)'(2**(LW-1) - 1);

  // clamp a one-bit-wider result to the symmetric range
  function automatic llr_t sat_sym(input logic signed [LW:0] x);
    if (x > LIMW)  return llr_t'(LIMW);
    if (x < -LIMW) return llr_t'(-LIMW);
    return llr_t'(x);
  endfunction

  function automatic llr_t sub_sat(input llr_t a, input llr_t b);
    logic signed [LW:0] aw, bw;
    aw = a; bw = b;
    return sat_sym(aw - bw);
  endfunction

  function automatic llr_t add_sat(input llr_t a, input llr_t b);
    logic signed [LW:0] aw, bw;
    aw = a; bw = b;
    return sat_sym(aw + bw);
  endfunction

  // two's complement to sign-magnitude (input already symmetric)
  function automatic sm_t to_sm(input llr_t v);
    sm_t r;
    llr_t a;
    a = v[LW-1] ? -v : v;
    r.s = v[LW-1];
    r.m = a[MW-1:0];
    return r;
  endfunction

  function automatic llr_t from_sm(input logic s, input mag_t m);
    llr_t p;
    p = llr_t'({1'b0, m});
    return s ? -p : p;
  endfunction

  function automatic mag_t off_clamp(input mag_t m, input int off);
    if (m > mag_t'(off)) return m - mag_t'(off);
    return '0;
  endfunction
endpackage

// File: rtl/cnu_sub.sv
`timescale 1ns/1ps
module cnu_sub import cnu_pkg::*; (
  input  llr_t app,
  input  llr_t old,
  output llr_t q,
  output sm_t  qsm
);
  assign q   = sub_sat(app, old);
  assign qsm = to_sm(q);
endmodule

// File: rtl/cnu_minsrch.sv
`timescale 1ns/1ps
module cnu_minsrch import cnu_pkg::*; #(
  parameter int IW = 5
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic          en1,
  input  logic [IW-1:0] base,
  input  sm_t           v0,
  input  sm_t           v1,
  output mag_t          min1,
  output mag_t          min2,
  output logic [IW-1:0] min_idx,
  output logic          sgn_all
);
  mag_t n1, n2;
  logic [IW-1:0] ni;
  logic ns;

  always_comb begin
    n1 = min1; n2 = min2; ni = min_idx; ns = sgn_all;
    if (v0.m < n1) begin n2 = n1; n1 = v0.m; ni = base; end
    else if (v0.m < n2) n2 = v0.m;
    ns = ns ^ v0.s;
    if (en1) begin
      if (v1.m < n1) begin n2 = n1; n1 = v1.m; ni = base + IW'(1); end
      else if (v1.m < n2) n2 = v1.m;
      ns = ns ^ v1.s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min1 <= '1; min2 <= '1; min_idx <= '0; sgn_all <= 1'b0;
    end else if (clr) begin
      min1 <= '1; min2 <= '1; min_idx <= '0; sgn_all <= 1'b0;
    end else if (upd) begin
      min1 <= n1; min2 <= n2; min_idx <= ni; sgn_all <= ns;
    end
  end
endmodule

// File: rtl/cnu_qbuf.sv
`timescale 1ns/1ps
module cnu_qbuf import cnu_pkg::*; #(
  parameter int NPAIR = 12,
  parameter int PW    = 4
)(
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  llr_t          wd0,
  input  llr_t          wd1,
  input  logic [PW-1:0] raddr,
  output llr_t          rd0,
  output llr_t          rd1
);
  llr_t mem0 [NPAIR];
  llr_t mem1 [NPAIR];

  always_ff @(posedge clk) begin
    if (we) begin
      mem0[waddr] <= wd0;
      mem1[waddr] <= wd1;
    end
  end

  assign rd0 = mem0[raddr];
  assign rd1 = mem1[raddr];
endmodule

// File: rtl/cnu_out.sv
`timescale 1ns/1ps
module cnu_out import cnu_pkg::*; #(
  parameter int IW = 5
)(
  input  logic          en,
  input  llr_t          q,
  input  logic          sgn_all,
  input  logic [IW-1:0] my_idx,
  input  logic [IW-1:0] min_idx,
  input  mag_t          m1c,
  input  mag_t          m2c,
  output llr_t          chk,
  output llr_t          app_new
);
  sm_t  qs;
  mag_t mg;
  llr_t r;

  assign qs  = to_sm(q);
  assign mg  = (my_idx == min_idx) ? m2c : m1c;
  assign r   = from_sm(sgn_all ^ qs.s, mg);
  assign chk     = en ? r : '0;
  assign app_new = en ? add_sat(q, r) : '0;
endmodule

// File: rtl/cnu_row.sv
`timescale 1ns/1ps
module cnu_row import cnu_pkg::*; #(
  parameter  int MAXDEG = 24,
  parameter  int OFFSET = 1,
  localparam int IW     = $clog2(MAXDEG + 1)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [IW-1:0]        row_deg,
  input  logic                 in_valid,
  input  logic                 in_lane1_ok,
  input  logic signed [LW-1:0] in_app0,
  input  logic signed [LW-1:0] in_app1,
  input  logic signed [LW-1:0] in_old0,
  input  logic signed [LW-1:0] in_old1,
  output logic                 out_valid,
  output logic                 out_lane1_ok,
  output logic signed [LW-1:0] out_app0,
  output logic signed [LW-1:0] out_app1,
  output logic signed [LW-1:0] out_chk0,
  output logic signed [LW-1:0] out_chk1,
  output logic                 done
);
  localparam int NPAIR = (MAXDEG + 1) / 2;
  localparam int PW    = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  cnu_state_t    st;
  logic [IW-1:0] deg_r, cnt, npair, min_idx;
  logic [IW:0]   cnt_nx;
  logic [PW-1:0] wp, rp;
  mag_t          min1, min2, m1c, m2c;
  logic          sgn_all;

  // named events, also used by the checker
  logic row_start, take, take1, emit, last_pair;
  assign row_start = start && (st == S_IDLE);
  assign take      = in_valid && (st == S_LOAD);
  assign take1     = take && in_lane1_ok;
  assign emit      = (st == S_EMIT);
  assign npair     = IW'(({1'b0, deg_r} + 1'b1) >> 1);
  assign last_pair = emit && ((IW'(rp) + IW'(1)) == npair);
  assign cnt_nx    = {1'b0, cnt} + (IW+1)'(1) + (IW+1)'(take1);

  llr_t app_a [2], old_a [2], q_a [2], qr_a [2], chk_a [2], apo_a [2];
  sm_t  sm_a  [2];
  logic en_o  [2];

  assign app_a[0] = in_app0;  assign app_a[1] = in_app1;
  assign old_a[0] = in_old0;  assign old_a[1] = in_old1;
  assign en_o[0]  = emit;
  assign en_o[1]  = out_lane1_ok;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    cnu_sub u_sub (.app(app_a[g]), .old(old_a[g]), .q(q_a[g]), .qsm(sm_a[g]));
    cnu_out #(.IW(IW)) u_out (
      .en(en_o[g]), .q(qr_a[g]), .sgn_all(sgn_all),
      .my_idx(IW'({rp, 1'b0}) + IW'(g)), .min_idx(min_idx),
      .m1c(m1c), .m2c(m2c), .chk(chk_a[g]), .app_new(apo_a[g]));
  end

  cnu_minsrch #(.IW(IW)) u_srch (
    .clk(clk), .rst_n(rst_n), .clr(row_start), .upd(take), .en1(take1),
    .base(cnt), .v0(sm_a[0]), .v1(sm_a[1]),
    .min1(min1), .min2(min2), .min_idx(min_idx), .sgn_all(sgn_all));

  cnu_qbuf #(.NPAIR(NPAIR), .PW(PW)) u_buf (
    .clk(clk), .we(take), .waddr(wp), .wd0(q_a[0]),
    .wd1(take1 ? q_a[1] : '0), .raddr(rp), .rd0(qr_a[0]), .rd1(qr_a[1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; deg_r <= '0; cnt <= '0; wp <= '0; rp <= '0;
      m1c <= '0; m2c <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_LOAD; deg_r <= row_deg; cnt <= '0; wp <= '0;
        end
        S_LOAD: if (take) begin
          cnt <= cnt_nx[IW-1:0];
          wp  <= wp + PW'(1);
          if (cnt_nx >= {1'b0, deg_r}) st <= S_FIN;
        end
        S_FIN: begin
          m1c <= off_clamp(min1, OFFSET);
          m2c <= off_clamp(min2, OFFSET);
          rp  <= '0;
          st  <= S_EMIT;
        end
        S_EMIT: begin
          rp <= rp + PW'(1);
          if (last_pair) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign out_valid    = emit;
  assign out_lane1_ok = emit && !(last_pair && deg_r[0]);
  assign done         = last_pair;
  assign out_chk0     = chk_a[0];
  assign out_chk1     = chk_a[1];
  assign out_app0     = apo_a[0];
  assign out_app1     = apo_a[1];
endmodule

// File: rtl/cnu_row_chk.sv
`timescale 1ns/1ps
module cnu_row_chk import cnu_pkg::*; #(
  parameter int OFFSET = 1
)(
  input logic       clk,
  input logic       rst_n,
  input logic       take,
  input logic       last_pair,
  input logic       out_valid,
  input logic       out_lane1_ok,
  input logic       done,
  input logic signed [LW-1:0] out_app0,
  input logic signed [LW-1:0] out_app1,
  input logic signed [LW-1:0] out_chk0,
  input logic signed [LW-1:0] out_chk1
);
  localparam int LIM  = 2**(LW-1) - 1;
  localparam int MAXM = (LIM > OFFSET) ? LIM - OFFSET : 0;

  // R8: done marks the final pair and the stream stops right after it
  a_r8_done_with_pair: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid && last_pair);
  a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !out_valid);

  // R6: output pairs come back to back until the last one
  a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !done |=> out_valid);

  // R9: loading and emitting never overlap
  a_r9_no_load_in_emit: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !out_valid);

  // R7: disabled lane reads zero
  a_r7_lane1_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_lane1_ok |-> out_chk1 == '0 && out_app1 == '0);

  // R5: posterior stays in the symmetric range
  a_r5_app_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_app0) >= -LIM && int'(out_app1) >= -LIM);

  // R3: offset always removed from the magnitude
  a_r3_mag_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_chk0) <= MAXM && int'(out_chk0) >= -MAXM &&
                  int'(out_chk1) <= MAXM && int'(out_chk1) >= -MAXM);
endmodule

bind cnu_row cnu_row_chk #(.OFFSET(OFFSET)) u_cnu_row_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .last_pair(last_pair),
  .out_valid(out_valid), .out_lane1_ok(out_lane1_ok), .done(done),
  .out_app0(out_app0), .out_app1(out_app1),
  .out_chk0(out_chk0), .out_chk1(out_chk1));

// File: tb/cnu_row_bench.sv
`timescale 1ns/1ps
module cnu_row_bench;
  localparam int OFF = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, in_lane1_ok = 1'b0;
  logic [4:0] row_deg = '0;
  logic signed [6:0] in_app0 = '0, in_app1 = '0, in_old0 = '0, in_old1 = '0;
  logic out_valid, out_lane1_ok, done;
  logic signed [6:0] out_app0, out_app1, out_chk0, out_chk1;

  cnu_row u_cnu_row (.*);

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0;
  int t_app [24], t_old [24], e_chk [24], e_app [24];

  // stimulus table: {degree, seed}
  localparam logic [15:0] VEC [8] = '{16'h1801, 16'h0702, 16'h0603, 16'h0D04,
                                      16'h0205, 16'h0306, 16'h1407, 16'h0B08};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp63(input int x);
    return (x > 63) ? 63 : (x < -63) ? -63 : x;
  endfunction

  // reference: pairwise exclusion over the row
  task automatic model(input int d);
    int q [24];
    for (int i = 0; i < d; i++) q[i] = clamp63(t_app[i] - t_old[i]);
    for (int i = 0; i < d; i++) begin
      int mn = 63, par = 0, m, r;
      for (int j = 0; j < d; j++) begin
        if (j != i) begin
          int a = (q[j] < 0) ? -q[j] : q[j];
          if (a < mn) mn = a;
          if (q[j] < 0) par ^= 1;
        end
      end
      m = (mn - OFF < 0) ? 0 : mn - OFF;
      r = par ? -m : m;
      e_chk[i] = r;
      e_app[i] = clamp63(q[i] + r);
    end
  endtask

  task automatic run_row(input int d, input bit poke);
    model(d);
    @(negedge clk); start = 1'b1; row_deg = 5'(d);
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < (d + 1) / 2; k++) begin
      in_valid = 1'b1;
      in_app0 = 7'(t_app[2*k]); in_old0 = 7'(t_old[2*k]);
      if (2*k + 1 < d) begin
        in_lane1_ok = 1'b1; in_app1 = 7'(t_app[2*k+1]); in_old1 = 7'(t_old[2*k+1]);
      end else begin
        in_lane1_ok = 1'b0; in_app1 = 7'sd1; in_old1 = -7'sd63; // junk, R7
      end
      if (poke && k == 0) begin start = 1'b1; row_deg = 5'd3; end // R9
      @(negedge clk);
      start = 1'b0;
    end
    in_valid = 1'b0; in_lane1_ok = 1'b0;
    check(out_valid == 1'b0, "R6 finalize gap", int'(out_valid), 0);
    @(negedge clk);
    for (int k = 0; k < (d + 1) / 2; k++) begin
      bit l1 = (2*k + 1 < d);
      bit lst = (k == (d + 1) / 2 - 1);
      if (poke && k == 0) begin start = 1'b1; row_deg = 5'd2; end // R9
      check(out_valid == 1'b1, "R6 out_valid", int'(out_valid), 1);
      check(out_lane1_ok == l1, "R7 lane1 flag", int'(out_lane1_ok), int'(l1));
      check(done == lst, "R8 done", int'(done), int'(lst));
      check(int'(out_chk0) == e_chk[2*k], "R3,R4 chk0", int'(out_chk0), e_chk[2*k]);
      check(int'(out_app0) == e_app[2*k], "R2,R5 app0", int'(out_app0), e_app[2*k]);
      check(int'(out_chk1) == (l1 ? e_chk[2*k+1] : 0), "R3,R4,R7 chk1",
            int'(out_chk1), l1 ? e_chk[2*k+1] : 0);
      check(int'(out_app1) == (l1 ? e_app[2*k+1] : 0), "R2,R5,R7 app1",
            int'(out_app1), l1 ? e_app[2*k+1] : 0);
      @(negedge clk);
      start = 1'b0;
    end
    check(out_valid == 1'b0, "R8 stream ends", int'(out_valid), 0);
  endtask

  function automatic int rnd7(inout int unsigned s);
    int v;
    s = s * 32'd1103515245 + 32'd12345;
    v = int'(s[22:16]);
    return (v > 63) ? v - 128 : v;
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && done == 1'b0, "R1 idle after reset", int'(out_valid), 0);

    // R9: in_valid while idle does nothing
    in_valid = 1'b1; in_lane1_ok = 1'b1; in_app0 = -7'sd64; in_app1 = 7'sd0;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R9 in_valid while idle", int'(out_valid), 0);
    end
    in_valid = 1'b0; in_lane1_ok = 1'b0;

    // table walk: random rows, degrees 2..24 (R10)
    for (int v = 0; v < 8; v++) begin
      int d = int'(VEC[v][15:8]);
      int unsigned s = 32'(VEC[v][7:0]);
      for (int i = 0; i < d; i++) begin
        t_app[i] = rnd7(s); t_old[i] = rnd7(s);
      end
      run_row(d, v == 3);
    end

    // R2,R5: saturation at both ends
    t_app[0] = 63;  t_old[0] = -63;
    t_app[1] = -64; t_old[1] = 63;
    t_app[2] = 10;  t_old[2] = 0;
    t_app[3] = -5;  t_old[3] = 3;
    run_row(4, 1'b0);

    // R3,R7: equal magnitudes, odd degree
    for (int i = 0; i < 3; i++) begin t_app[i] = (i == 1) ? -5 : 5; t_old[i] = 0; end
    run_row(3, 1'b0);

    // R3: offset floor at zero, minimum degree
    t_app[0] = 0; t_old[0] = 0; t_app[1] = -1; t_old[1] = 0;
    run_row(2, 1'b0);

    // R9: stray start during load and emit
    for (int i = 0; i < 9; i++) begin t_app[i] = 3*i - 12; t_old[i] = 2 - i; end
    run_row(9, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule